// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block models the device side of one interrupt priority level on which several
devices share a single active-low request line. Each device stage holds a pending
flag that is set by a one-cycle raise pulse. While the flag is set, the stage pulls
the shared request line low. The shared line is the AND of all stage outputs, so any
number of devices can request at once without disturbing one another.

The processor answers with one acknowledge line, which enters the stage nearest to
it (index 0). A stage that has nothing pending lets the acknowledge through to the
next stage in the same cycle. A pending stage keeps the acknowledge and drives its
10-bit vector onto the shared vector bus for as long as the acknowledge stays high.
Its pending flag is cleared once the acknowledge has gone low again. Priority among
the devices therefore follows their position along the chain: the stage with the
lowest index wins.

The decision to claim or to pass is taken when the acknowledge first arrives and is
then held for the whole acknowledge pulse. A request that is raised partway through
a pulse does not claim that pulse. It waits for the next one.

Top module: `irq_chain_top`

## Requirements
- R1: After a synchronous active-low reset, no stage is pending: `irq_n_o` is 1, `ack_tail_o` is 0, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: A raise pulse on bit i of `raise_i`, sampled at a clock edge, makes stage i pending from that edge on. `irq_n_o` is 0 whenever one or more stages are pending and 1 when none is.
- R3: A stage with no request passes the acknowledge to the next stage within the same cycle, with no register on the path.
- R4: When the acknowledge arrives, the pending stage with the lowest index claims it. No stage past the claimant sees the acknowledge, and `ack_tail_o` stays 0.
- R5: While it holds the acknowledge, the claiming stage i drives bits [10*i+9 : 10*i] of `vec_tab_i` onto `vec_o` and raises `vec_valid_o`. When no stage holds the acknowledge, `vec_o` is 0 and `vec_valid_o` is 0.
- R6: The claimant's pending flag clears at the first clock edge that samples the acknowledge low after the claim. Other pending stages keep their requests.
- R7: A request raised while the acknowledge is already passing through that stage does not claim it. The acknowledge keeps reaching `ack_tail_o` until it falls, and the stage claims the next acknowledge pulse.
- R8: An acknowledge given while no stage is pending emerges at `ack_tail_o` in the same cycle.
- R9: A raise pulse in the same cycle as a claimant's clearing edge leaves that stage pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | 4 | One-cycle raise pulse per stage, bit i for stage i |
| ack_i | input | 1 | Acknowledge from the processor, entering stage 0 |
| vec_tab_i | input | 40 | Vector of each stage, 10 bits per stage, stage i at [10*i+9:10*i] |
| irq_n_o | output | 1 | Shared active-low request line (AND of all stages) |
| ack_tail_o | output | 1 | Acknowledge leaving the last stage, unclaimed |
| vec_valid_o | output | 1 | A stage is driving the vector bus |
| vec_o | output | 10 | Vector bus |

## Verification
All 16 patterns of pending stages are raised in turn. For each pattern the chain is
acknowledged repeatedly until it drains. Each pulse must return the vector of the
lowest pending index and strip exactly that index from the pattern, which shows
positional priority, the blocking of the acknowledge and clearing of one stage only.
The empty pattern and the drained end of every sweep show the acknowledge reaching
the tail. Two directed sequences cover the remaining cases: a request raised in the
middle of a passing pulse, which must not claim until the next pulse, and a raise
pulse that coincides with the clearing edge, which must leave the stage pending.

// File: rtl/irq_chain_pkg.sv
// Package: shared sizing for the acknowledge chain.
// Assumes: one priority level, vectors of a fixed width per build.
package irq_chain_pkg;
    localparam int unsigned VEC_W = 10;  // vector bus width
    localparam int unsigned N_DEV = 4;   // stages in the chain
endpackage

// File: rtl/irq_chain_stage.sv
// Module: irq_chain_stage
// One device on a shared interrupt level. It holds a pending flag and pulls the
// shared request low while the flag is set. On the arrival of an acknowledge it
// either claims it (when pending) or passes it on combinationally. That choice is
// held for the whole acknowledge pulse.
// Assumes: ack_i is a level that stays high for at least one clock edge;
// raise_i is a one-cycle pulse.
module irq_chain_stage #(
    parameter int unsigned VEC_W = irq_chain_pkg::VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_i,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             ack_o,
    output logic             req_n_o,
    output logic             vec_oe_o,
    output logic [VEC_W-1:0] vec_o
);
    logic pend_q;    // request flag
    logic ack_q;     // acknowledge seen at the previous edge
    logic own_q;     // this stage holds the current acknowledge
    logic owned;

    // Claim decision: taken from pend_q on the first cycle, then held.
    always_comb begin
        owned = ack_i & (ack_q ? own_q : pend_q);
    end

    // Track the acknowledge level and the held claim decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            own_q <= 1'b0;
        end else begin
            ack_q <= ack_i;
            own_q <= owned;
        end
    end

    // Pending flag: a raise sets it; the falling acknowledge after a claim clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (raise_i) begin
            pend_q <= 1'b1;
        end else if (own_q && !ack_i) begin
            pend_q <= 1'b0;
        end
    end

    assign ack_o    = ack_i & ~owned;
    assign req_n_o  = ~pend_q;
    assign vec_oe_o = owned;
    assign vec_o    = owned ? vec_i : '0;

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i |=> !req_n_o); // R2
    AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_q) |-> (vec_oe_o == $past(vec_oe_o))); // R7
    AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && !ack_i && !raise_i) |=> req_n_o); // R6
    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> (!ack_o && !vec_oe_o)); // R3
endmodule

// File: rtl/irq_chain_vecmux.sv
// Module: irq_chain_vecmux
// Merges the gated vectors of all stages onto one bus, the way open-drain
// drivers share lines. At most one stage drives at a time.
// Assumes: a stage presents zero on vec_all_i when it is not driving.
module irq_chain_vecmux #(
    parameter int unsigned VEC_W = irq_chain_pkg::VEC_W,
    parameter int unsigned N_DEV = irq_chain_pkg::N_DEV
) (
    input  logic [N_DEV*VEC_W-1:0] vec_all_i,
    input  logic [N_DEV-1:0]       oe_i,
    output logic [VEC_W-1:0]       vec_o,
    output logic                   valid_o
);
    // OR the gated vectors together.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < int'(N_DEV); i++) begin
            vec_o = vec_o | vec_all_i[i*VEC_W +: VEC_W];
        end
    end

    assign valid_o = |oe_i;
endmodule

// File: rtl/irq_chain_top.sv
// Module: irq_chain_top
// Chain of N_DEV stages on one interrupt level. The acknowledge ripples from
// stage 0 onward, and the request line is the wired AND of every stage.
// Assumes: stage 0 sits nearest the processor and has the highest priority.
module irq_chain_top #(
    parameter int unsigned VEC_W = irq_chain_pkg::VEC_W,
    parameter int unsigned N_DEV = irq_chain_pkg::N_DEV
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DEV-1:0]       raise_i,
    input  logic                   ack_i,
    input  logic [N_DEV*VEC_W-1:0] vec_tab_i,
    output logic                   irq_n_o,
    output logic                   ack_tail_o,
    output logic                   vec_valid_o,
    output logic [VEC_W-1:0]       vec_o
);
    localparam int unsigned BUS_W = N_DEV * VEC_W;

    logic [N_DEV:0]     ack_link;
    logic [N_DEV-1:0]   req_n;
    logic [N_DEV-1:0]   oe;
    logic [BUS_W-1:0]   vec_gated;

    assign ack_link[0] = ack_i;

    // One stage per device, linked nearest-first.
    for (genvar g = 0; g < int'(N_DEV); g++) begin : g_stage
        irq_chain_stage #(.VEC_W(VEC_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .raise_i  (raise_i[g]),
            .ack_i    (ack_link[g]),
            .vec_i    (vec_tab_i[g*VEC_W +: VEC_W]),
            .ack_o    (ack_link[g+1]),
            .req_n_o  (req_n[g]),
            .vec_oe_o (oe[g]),
            .vec_o    (vec_gated[g*VEC_W +: VEC_W])
        );
    end

    irq_chain_vecmux #(.VEC_W(VEC_W), .N_DEV(N_DEV)) u_vecmux (
        .vec_all_i (vec_gated),
        .oe_i      (oe),
        .vec_o     (vec_o),
        .valid_o   (vec_valid_o)
    );

    assign irq_n_o    = &req_n;
    assign ack_tail_o = ack_link[N_DEV];

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe)); // R4
    AST_CLAIM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|oe) |-> !ack_tail_o); // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == '0)); // R5
    AST_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_n_o) |-> ack_tail_o); // R8
endmodule

// File: tb/irq_chain_top_bench.sv
// Bench: sweeps every pending pattern, drains the chain by acknowledge pulses and
// checks priority, vectors and clearing. Also covers the mid-pulse and
// coincident-raise cases.
module irq_chain_top_bench;
    localparam int VW = 10;
    localparam int ND = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ND-1:0]   raise = '0;
    logic            ack = 1'b0;
    logic [ND*VW-1:0] vtab;
    logic            irq_n, tail, vvalid;
    logic [VW-1:0]   vbus;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    irq_chain_top u_irq_chain_top (
        .clk(clk), .rst_n(rst_n), .raise_i(raise), .ack_i(ack),
        .vec_tab_i(vtab), .irq_n_o(irq_n), .ack_tail_o(tail),
        .vec_valid_o(vvalid), .vec_o(vbus)
    );

    function automatic logic [VW-1:0] vec_of(int i);
        return VW'(10'h100 + 10'h05B * i);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse the raise inputs for one edge.
    task automatic do_raise(input logic [ND-1:0] m);
        raise = m;
        @(negedge clk);
        raise = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; raise = '0; ack = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < ND; i++) vtab[i*VW +: VW] = vec_of(i);
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(irq_n == 1'b1, "R1 irq", int'(irq_n), 1);
        check(tail == 1'b0 && vvalid == 1'b0 && vbus == '0, "R1 outputs",
              int'({tail, vvalid, vbus}), 0);

        for (int m = 0; m < 16; m++) begin
            logic [ND-1:0] left;
            do_reset();
            do_raise(ND'(m));
            left = ND'(m);
            check(irq_n == (m == 0), "R2 line", int'(irq_n), int'(m == 0));
            for (int k = 0; k <= ND; k++) begin
                int win;
                win = -1;
                for (int b = ND - 1; b >= 0; b--) if (left[b]) win = b;
                ack = 1'b1;
                #1;
                if (win < 0) begin
                    check(tail == 1'b1, "R8 tail", int'(tail), 1);
                    check(vvalid == 1'b0 && vbus == '0, "R5 quiet",
                          int'({vvalid, vbus}), 0);
                end else begin
                    check(tail == 1'b0, "R4 blocked", int'(tail), 0);
                    check(vvalid == 1'b1 && vbus == vec_of(win), "R5 vector",
                          int'(vbus), int'(vec_of(win)));
                end
                @(negedge clk);
                // R4 decision held across the second cycle of the pulse
                if (win >= 0)
                    check(vbus == vec_of(win) && tail == 1'b0, "R4 hold",
                          int'(vbus), int'(vec_of(win)));
                ack = 1'b0;
                @(negedge clk);
                if (win >= 0) left[win] = 1'b0;
                check(irq_n == (left == '0), "R6 cleared one", int'(irq_n),
                      int'(left == '0));
                if (win < 0) break;
            end
        end

        // R7 request raised mid-pulse does not claim
        do_reset();
        ack = 1'b1;
        @(negedge clk);
        do_raise(4'b0100);
        check(irq_n == 1'b0, "R7 line low", int'(irq_n), 0);
        check(tail == 1'b1 && vvalid == 1'b0, "R7 still passing",
              int'({tail, vvalid}), 2);
        @(negedge clk);
        check(tail == 1'b1, "R7 still passing later", int'(tail), 1);
        ack = 1'b0;
        @(negedge clk);
        check(irq_n == 1'b0, "R7 request kept", int'(irq_n), 0);
        ack = 1'b1;
        #1;
        check(vvalid == 1'b1 && vbus == vec_of(2) && tail == 1'b0, "R7 next pulse claims",
              int'(vbus), int'(vec_of(2)));
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check(irq_n == 1'b1, "R6 drained", int'(irq_n), 1);

        // R3 pass-through with no request: same cycle as ack rises
        ack = 1'b1;
        #1;
        check(tail == 1'b1, "R3 combinational pass", int'(tail), 1);
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);

        // R9 raise coincides with the clearing edge
        do_raise(4'b0001);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        raise = 4'b0001;
        @(negedge clk);
        raise = '0;
        check(irq_n == 1'b0, "R9 re-pending", int'(irq_n), 0);
        ack = 1'b1;
        #1;
        check(vbus == vec_of(0), "R9 claims again", int'(vbus), int'(vec_of(0)));
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check(irq_n == 1'b1, "R9 then clears", int'(irq_n), 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule